// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is the switching core for eight serial time-division-multiplexed links in and eight out. Each link carries a frame of 32 byte-wide channels at 2.048 Mbit/s. The block runs from a 4.096 MHz clock, two clocks per bit. Every incoming frame is stored in a data memory that is double-buffered by frame parity. For each of the 256 output slots, a connection memory says which input stream and channel feeds it. It is non-blocking, so any input slot may feed any number of output slots.

Each connection entry holds four flags. The first picks constant or minimum (variable) frame delay, so that a group of channels making up one wideband channel stays in sequence. The second replaces switched data with the entry's own byte, which gives message insertion. The third gates the output slot's drive enable. The fourth sets one bit of a separate 256-bit-per-frame control serial stream. A global drive-enable input overrides every per-slot enable. A host loads entries through a single-cycle write port.

Top module: `tsi_switch`

## Requirements
- R1: Timing. A frame is 512 clocks. A frame pulse seen at a clock edge makes the next cycle clock 0. Channel c spans clocks 16c to 16c+15, and bit b of that channel (b=0 is the MSB) spans clocks 16c+2b and 16c+2b+1. Each input bit is sampled at the clock edge that ends the second of its two clocks. Each output bit is held steady for both of its clocks.
- R2: A connection entry is 12 bits. Bits [7:0] are the source byte: stream in [7:5] and channel in [4:0], or the message byte in message mode. Bit 8 is the slot enable, bit 9 selects constant delay, bit 10 selects message mode and bit 11 is the control-stream bit. The write address is {stream[7:5], channel[4:0]} of the output slot.
- R3: Any output slot may carry any input slot, and several output slots may carry the same input slot in the same frame.
- R4: A constant-delay slot in output frame F carries the source byte received in frame F-1.
- R5: A variable-delay slot c carries the frame-F source byte when the source channel is at most c-1. Otherwise it carries the frame F-1 byte, and output channel 0 always carries the frame F-1 byte.
- R6: A message-mode slot transmits bits [7:0] of its entry.
- R7: With the global enable high, a slot's drive enable follows bit 8 of its entry.
- R8: With the global enable low, all eight drive enables are low in the same cycle.
- R9: During bit b of channel c, the control output carries bit 11 of the entry for stream b, channel c.
- R10: A write to an entry takes effect from the next start of that output slot. A slot already being serialised finishes with the old setting.
- R11: After reset all connection entries are zero, and the serial outputs, drive enables and control output are low until the first slot load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz clock, two per bit |
| rst | input | 1 | Synchronous active-high reset |
| frm_i | input | 1 | Frame pulse; next cycle is clock 0 of a frame |
| rx_i | input | 8 | Serial input streams |
| ode_i | input | 1 | Global drive enable for all outputs |
| cm_we_i | input | 1 | Connection entry write strobe |
| cm_addr_i | input | 8 | Output slot address {stream, channel} |
| cm_wdata_i | input | 12 | Connection entry value |
| tx_o | output | 8 | Serial output streams |
| tx_oe_o | output | 8 | Per-stream drive enable (low means high impedance) |
| ctl_o | output | 1 | Control serial stream |

## Verification
A frame counter or parity bit that slips would put bytes from the wrong frame on the constant and variable slots. That shows in the first output channel after the slip, because each byte is checked against its own source frame. A mis-latched connection entry corrupts only the next serialised slot and the control bits of that channel, so the error appears within 16 clocks. A drive-enable gating fault shows in the same cycle. Mid-slot entry writes and the same-edge bypass of the last received channel are aimed at directly, because a fault there shows only in a single slot per frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int NSTR  = 8;
    localparam int NCH   = 32;
    localparam int BW    = 8;
    localparam int SW    = $clog2(NSTR);
    localparam int CW    = $clog2(NCH);
    localparam int BIW   = $clog2(BW);
    localparam int FW    = CW + BIW + 1;
    localparam int AW    = SW + CW;
    localparam int NFLAG = 4;
    localparam int CMW   = BW + NFLAG;

    typedef logic [SW-1:0]  str_t;
    typedef logic [CW-1:0]  chan_t;
    typedef logic [BIW-1:0] bit_t;
    typedef logic [BW-1:0]  byte_t;
    typedef logic [FW-1:0]  fcnt_t;

    // connection entry: flags above the source/message byte
    typedef struct packed {
        logic  ctl;
        logic  msg;
        logic  cdly;
        logic  oe;
        byte_t low;
    } cm_entry_t;

    function automatic str_t src_str(byte_t b);
        return b[BW-1 -: SW];
    endfunction

    function automatic chan_t src_chan(byte_t b);
        return b[CW-1:0];
    endfunction

    function automatic chan_t fc_chan(fcnt_t f);
        return f[FW-1 -: CW];
    endfunction

    function automatic bit_t fc_bit(fcnt_t f);
        return f[BIW:1];
    endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frm_i,
    output fcnt_t fc,
    output logic  par
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fc  <= '0;
            par <= 1'b0;
        end else begin
            fc <= frm_i ? '0 : fc + 1'b1;
            if (frm_i || fc == '1) begin
                par <= ~par;
            end
        end
    end
endmodule

// File: rtl/tsi_rx_capture.sv
module tsi_rx_capture
    import tsi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_stb,
    input  logic                   end_stb,
    input  logic                   par,
    input  chan_t                  wch,
    input  logic  [NSTR-1:0]       rx_i,
    input  logic  [NSTR-1:0]       rd_buf,
    input  byte_t [NSTR-1:0]       rd_src,
    output byte_t [NSTR-1:0]       rd_data
);
    logic  [NSTR-1:0][BW-2:0] shr;
    byte_t [NSTR-1:0]         fresh;
    byte_t                    dmem [2][NSTR][NCH];

    generate
        for (genvar s = 0; s < NSTR; s++) begin : g_in
            assign fresh[s] = {shr[s], rx_i[s]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            shr <= '0;
        end else if (smp_stb) begin
            for (int s = 0; s < NSTR; s++) begin
                shr[s] <= fresh[s][BW-2:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && end_stb) begin
            for (int s = 0; s < NSTR; s++) begin
                dmem[par][s][wch] <= fresh[s];
            end
        end
    end

    // read ports; a read of the slot being written this edge takes the fresh byte
    generate
        for (genvar p = 0; p < NSTR; p++) begin : g_rd
            str_t  ss;
            chan_t sc;
            logic  hit;
            assign ss  = src_str(rd_src[p]);
            assign sc  = src_chan(rd_src[p]);
            assign hit = (rd_buf[p] == par) && (sc == wch);
            assign rd_data[p] = hit ? fresh[ss] : dmem[rd_buf[p]][ss][sc];
        end
    endgenerate
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic      [AW-1:0]    waddr,
    input  cm_entry_t             wdata,
    input  chan_t                 rd_chan,
    output cm_entry_t [NSTR-1:0]  rd_ent
);
    cm_entry_t cmem [NSTR*NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSTR*NCH; i++) begin
                cmem[i] <= '0;
            end
        end else if (we) begin
            cmem[waddr] <= wdata;
        end
    end

    generate
        for (genvar t = 0; t < NSTR; t++) begin : g_rd
            assign rd_ent[t] = cmem[{str_t'(t), rd_chan}];
        end
    endgenerate
endmodule

// File: rtl/tsi_tx_path.sv
module tsi_tx_path
    import tsi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  end_stb,
    input  logic                  par,
    input  chan_t                 wch,
    input  cm_entry_t [NSTR-1:0]  ent,
    input  byte_t     [NSTR-1:0]  rd_data,
    output logic      [NSTR-1:0]  rd_buf,
    output byte_t     [NSTR-1:0]  rd_src,
    output byte_t     [NSTR-1:0]  ob,
    output logic      [NSTR-1:0]  oe_l,
    output logic      [NSTR-1:0]  ctl_l
);
    logic wrap;
    assign wrap = (wch == chan_t'(NCH-1));

    // buffer choice for the slot loaded at this edge:
    // at the frame wrap the current buffer is the one just completed
    generate
        for (genvar t = 0; t < NSTR; t++) begin : g_sel
            assign rd_src[t] = ent[t].low;
            assign rd_buf[t] = wrap        ? par :
                               ent[t].cdly ? ~par :
                               (src_chan(ent[t].low) <= wch) ? par : ~par;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ob    <= '0;
            oe_l  <= '0;
            ctl_l <= '0;
        end else if (end_stb) begin
            for (int t = 0; t < NSTR; t++) begin
                ob[t]    <= ent[t].msg ? ent[t].low : rd_data[t];
                oe_l[t]  <= ent[t].oe;
                ctl_l[t] <= ent[t].ctl;
            end
        end
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            frm_i,
    input  logic [NSTR-1:0] rx_i,
    input  logic            ode_i,
    input  logic            cm_we_i,
    input  logic [AW-1:0]   cm_addr_i,
    input  logic [CMW-1:0]  cm_wdata_i,
    output logic [NSTR-1:0] tx_o,
    output logic [NSTR-1:0] tx_oe_o,
    output logic            ctl_o
);
    fcnt_t                 fc;
    logic                  par;
    logic                  smp_stb;
    logic                  end_stb;
    chan_t                 wch;
    chan_t                 nch;
    bit_t                  bitn;
    cm_entry_t [NSTR-1:0]  ent;
    logic      [NSTR-1:0]  rd_buf;
    byte_t     [NSTR-1:0]  rd_src;
    byte_t     [NSTR-1:0]  rd_data;
    byte_t     [NSTR-1:0]  ob;
    logic      [NSTR-1:0]  oe_l;
    logic      [NSTR-1:0]  ctl_l;

    assign smp_stb = fc[0];
    assign end_stb = &fc[BIW:0];
    assign wch     = fc_chan(fc);
    assign nch     = wch + 1'b1;
    assign bitn    = fc_bit(fc);

    tsi_frame_timer u_tmr (
        .clk   (clk),
        .rst   (rst),
        .frm_i (frm_i),
        .fc    (fc),
        .par   (par)
    );

    tsi_rx_capture u_rx (
        .clk     (clk),
        .rst     (rst),
        .smp_stb (smp_stb),
        .end_stb (end_stb),
        .par     (par),
        .wch     (wch),
        .rx_i    (rx_i),
        .rd_buf  (rd_buf),
        .rd_src  (rd_src),
        .rd_data (rd_data)
    );

    tsi_conn_mem u_cm (
        .clk     (clk),
        .rst     (rst),
        .we      (cm_we_i),
        .waddr   (cm_addr_i),
        .wdata   (cm_entry_t'(cm_wdata_i)),
        .rd_chan (nch),
        .rd_ent  (ent)
    );

    tsi_tx_path u_tx (
        .clk     (clk),
        .rst     (rst),
        .end_stb (end_stb),
        .par     (par),
        .wch     (wch),
        .ent     (ent),
        .rd_data (rd_data),
        .rd_buf  (rd_buf),
        .rd_src  (rd_src),
        .ob      (ob),
        .oe_l    (oe_l),
        .ctl_l   (ctl_l)
    );

    generate
        for (genvar t = 0; t < NSTR; t++) begin : g_out
            assign tx_o[t] = ob[t][~bitn];
        end
    endgenerate

    assign tx_oe_o = oe_l & {NSTR{ode_i}};
    assign ctl_o   = ctl_l[bitn];
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_i,
    input  logic                ode_i,
    input  logic                end_stb,
    input  logic                par,
    input  fcnt_t               fc,
    input  logic  [NSTR-1:0]    tx_o,
    input  logic  [NSTR-1:0]    tx_oe_o,
    input  byte_t [NSTR-1:0]    ob
);
    // R1: frame pulse restarts the frame count
    p_frame_restart_r1: assert property (@(posedge clk) disable iff (rst)
        frm_i |=> (fc == '0));

    // R1: each output bit holds for both of its clocks
    p_bit_hold_r1: assert property (@(posedge clk) disable iff (rst)
        fc[0] |-> $stable(tx_o));

    // R4: buffer parity flips at every frame boundary
    p_par_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (fc == '1 || frm_i) |=> (par != $past(par)));

    // R8: global enable low forces all drive enables low
    p_ode_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !ode_i |-> (tx_oe_o == '0));

    // R10: latched slot bytes change only at a slot load
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !end_stb |=> $stable(ob));
endmodule

bind tsi_switch tsi_switch_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .frm_i   (frm_i),
    .ode_i   (ode_i),
    .end_stb (end_stb),
    .par     (par),
    .fc      (fc),
    .tx_o    (tx_o),
    .tx_oe_o (tx_oe_o),
    .ob      (ob)
);

// File: tb/test_tsi_switch.sv
`timescale 1ns/1ps
module test_tsi_switch;
    localparam int NCYC = 12 * 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm = 1'b0;
    logic [7:0]  rx = '0;
    logic        ode = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [11:0] wd = '0;
    logic [7:0]  tx;
    logic [7:0]  txoe;
    logic        ctl;

    always #2.5 clk = ~clk;

    tsi_switch i_tsi_switch (
        .clk        (clk),
        .rst        (rst),
        .frm_i      (frm),
        .rx_i       (rx),
        .ode_i      (ode),
        .cm_we_i    (we),
        .cm_addr_i  (addr),
        .cm_wdata_i (wd),
        .tx_o       (tx),
        .tx_oe_o    (txoe),
        .ctl_o      (ctl)
    );

    int nchk = 0;
    int nfail = 0;
    logic [7:0]  indat [4][8][32];
    logic [11:0] cm_sh [256];
    logic [11:0] snap [8];
    logic [7:0]  expb [8];
    logic [7:0]  gotb [8];
    bit          valid = 0;
    bit          ode_cur = 0;
    int          cur_fo = 0;
    int          cur_ch = 0;

    task automatic chk(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // R2 entry layout: [7:5] stream, [4:0] channel, 8 oe, 9 const, 10 msg, 11 ctl
    function automatic logic [11:0] gen_entry(int ph, int t, int c);
        logic [11:0] e;
        e[7:0] = 8'($urandom);
        e[8]   = ($urandom % 4) != 0;
        e[9]   = $urandom % 2;
        e[10]  = ($urandom % 4) == 0;
        e[11]  = $urandom % 2;
        if (ph == 1) begin
            if (t == 4) e = {4'b0001, 3'd5, 5'd7};                      // R3 multicast
            if (t == 0 && c == 0) e = {4'b0001, 3'd7, 5'd31};           // R5 ch0 var
            if (t == 0 && c == 1) e = {4'b0001, 3'd1, 5'd0};            // R5 bypass
            if (t == 0 && c == 2) e = {4'b0001, 3'd2, 5'd2};            // R5 same slot
            if (t == 1 && c == 0) e = {4'b0011, 3'd3, 5'd31};           // R4 wrap
            if (t == 1 && c >= 5 && c <= 9) e = {4'b0011, 3'd4, 5'(c + 15)}; // R4 group
            if (t == 2 && c == 3) e = {4'b0101, 8'h5A};                 // R6
            if (t == 3 && c == 4) e[8] = 1'b0;                          // R7
        end
        if (ph == 2) begin
            e[9]  = 1'b1;
            e[10] = 1'b0;
            e[11] = 1'(c ^ t);
        end
        return e;
    endfunction

    function automatic logic [7:0] expect_byte(logic [11:0] e, int och, int fo);
        int s = int'(e[7:5]);
        int c = int'(e[4:0]);
        int cur = fo % 4;
        int prv = (fo + 3) % 4;
        if (e[10]) return e[7:0];
        if (e[9]) return indat[prv][s][c];
        if (och != 0 && c <= och - 1) return indat[cur][s][c];
        return indat[prv][s][c];
    endfunction

    task automatic step(int k);
        int f  = k / 512;
        int fc = k % 512;
        int ch = fc / 16;
        int b  = (fc / 2) % 8;
        string lbl;
        if (k < 16) begin
            chk(tx == 8'h00, "R11 tx", int'(tx), 0);
            chk(txoe == 8'h00, "R11 oe", int'(txoe), 0);
            chk(ctl == 1'b0, "R11 ctl", int'(ctl), 0);
        end
        if (fc % 2 == 1) begin
            for (int t = 0; t < 8; t++) gotb[t] = {gotb[t][6:0], tx[t]};
            if (valid) chk(ctl == snap[b][11], "R9 control bit", int'(ctl), int'(snap[b][11]));
        end
        if (fc % 16 == 15) begin
            if (valid) begin
                for (int t = 0; t < 8; t++) begin
                    if (t == 2 && cur_ch == 5 && (cur_fo == 9 || cur_fo == 10)) lbl = "R10 late write";
                    else if (snap[t][10]) lbl = "R6 message";
                    else if (snap[t][9]) lbl = "R4 constant (R1 R2 R3)";
                    else lbl = "R5 variable (R1 R2 R3)";
                    chk(gotb[t] == expb[t], lbl, int'(gotb[t]), int'(expb[t]));
                    chk(txoe[t] == (ode_cur & snap[t][8]), ode_cur ? "R7 slot enable" : "R8 global enable",
                        int'(txoe[t]), int'(ode_cur & snap[t][8]));
                end
            end
            begin
                int nch = (ch + 1) % 32;
                int fo = (nch == 0) ? f + 1 : f;
                for (int t = 0; t < 8; t++) begin
                    snap[t] = cm_sh[t*32 + nch];
                    expb[t] = expect_byte(snap[t], nch, fo);
                end
                valid  = (fo >= 1);
                cur_fo = fo;
                cur_ch = nch;
            end
        end
        if (fc == 0) begin
            for (int s = 0; s < 8; s++)
                for (int c = 0; c < 32; c++) indat[f%4][s][c] = 8'($urandom);
        end
        // drive this cycle's inputs
        for (int s = 0; s < 8; s++) rx[s] = indat[f%4][s][ch][7-b];
        frm = (fc == 511);
        ode = (f != 6);
        ode_cur = ode;
        we = 1'b0;
        if ((f == 1 || f == 4 || f == 7) && fc < 256) begin
            int ph = (f == 1) ? 0 : (f == 4) ? 1 : 2;
            logic [11:0] e = gen_entry(ph, fc / 32, fc % 32);
            we = 1'b1;
            addr = 8'(fc);
            wd = e;
            cm_sh[fc] = e;
        end
        if (f == 9 && fc == 86) begin
            // R10: rewrite stream 2 channel 5 while it is being sent
            we = 1'b1;
            addr = 8'(2*32 + 5);
            wd = {4'b0101, 8'hA5};
            cm_sh[2*32 + 5] = {4'b0101, 8'hA5};
        end
    endtask

    initial begin
        #500000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) cm_sh[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(txoe == 8'h00 && tx == 8'h00, "R11 in reset", int'({txoe, tx}), 0);
        rst = 1'b0;
        for (int k = 0; k < NCYC; k++) begin
            if (k > 0) @(negedge clk);
            step(k);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule